// File: doc/BRIEF.md
# Fractional Clock Divider Phase Controller

This block is the sequencing logic of a multi-phase clock divider. A delay line outside the block offers 64 equally spaced taps across one period of a fast source clock, and a tap multiplexer (also outside) builds the divided clock by switching between taps. On every output cycle the block names the tap for the rising edge, the tap for the falling edge and a tap a quarter source period later for a quadrature companion clock. Successive rising edges are spaced by 64 plus a divisor plus a signed correction, counted in taps. The output period is therefore (64 + divisor)/64 source periods, adjustable in 1/64 steps, and the tap index wraps freely so phase can rotate without bound.

After reset the divider sits in bypass, where the source clock halved is used downstream. It leaves bypass only on a synchronous start pulse that arrives while the delay line reports lock, so that several dividers sharing the pulse begin their sequences together at tap 0. While running, a variable mode lets up and down requests move the divisor by one step at a time, bounded by programmable limits. Four signed correction terms are summed into every step. The alignment term is dropped in variable mode.

Top module: `fdiv_phase_ctrl`

## Requirements
- R1: After reset `bypass_o` is 1, `edge_vld_o` is 0, and `rise_ph_o`, `fall_ph_o`, `quad_ph_o` and `div_o` are all 0.
- R2: Bypass is left only in a cycle where `start_i` and `dll_lock_i` are both 1. In the next cycle `bypass_o` is 0, `edge_vld_o` is 1, `rise_ph_o` is 0 and `div_o` equals the `cfg_div_i` sampled with the pulse. A start pulse without lock, or a start pulse while running, has no effect.
- R3: While running, each cycle sets `rise_ph_o` to (previous `rise_ph_o` + previous `div_o` + offset sum) mod 64. With a divisor of 0 and a zero offset sum, the index does not move.
- R4: `fall_ph_o` equals (`rise_ph_o` + floor((64 + `div_o`)/2)) mod 64 in every running cycle.
- R5: `quad_ph_o` equals (`rise_ph_o` + 16) mod 64 in every running cycle.
- R6: The offset sum adds four 4-bit two's-complement terms (voltage, shrink, alignment, test). The alignment term is left out when `mode_var_i` is 1.
- R7: `adj_cmd_i` encodes 2'b01 = up (divisor + 1), 2'b10 = down (divisor − 1), and 2'b00 or 2'b11 = hold. Requests act only when `mode_var_i` is 1. In fixed mode the divisor does not change. The new divisor appears on `div_o` one cycle after the request.
- R8: An up request with `div_o` ≥ `lim_max_i`, or a down request with `div_o` ≤ `lim_min_i`, is treated as hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one cycle per output cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| dll_lock_i | input | 1 | Delay line lock indication |
| start_i | input | 1 | Shared synchronous start pulse |
| mode_var_i | input | 1 | 1 = variable mode, 0 = fixed mode |
| cfg_div_i | input | 6 | Divisor loaded at start |
| lim_min_i | input | 6 | Lowest divisor reachable by down requests |
| lim_max_i | input | 6 | Highest divisor reachable by up requests |
| adj_cmd_i | input | 2 | Adjust request: 01 up, 10 down, 00/11 hold |
| off_volt_i | input | 4 | Signed voltage-driven offset |
| off_shrink_i | input | 4 | Signed clock-shrink offset |
| off_align_i | input | 4 | Signed alignment offset |
| off_test_i | input | 4 | Signed test-loopback offset |
| bypass_o | output | 1 | 1 while the halved source clock is used |
| edge_vld_o | output | 1 | Phase indices are valid for this output cycle |
| rise_ph_o | output | 6 | Tap index of the rising edge |
| fall_ph_o | output | 6 | Tap index of the falling edge |
| quad_ph_o | output | 6 | Tap index of the quadrature edge |
| div_o | output | 6 | Divisor in use |

## Verification
The assertions check several properties on every cycle. Bypass and valid never overlap, and the first valid edge lands on tap 0. Bypass holds while lock is absent. The divisor moves by at most one per cycle, stays fixed outside variable mode and holds at the upper limit. A zero step leaves the rising tap in place. The dropped alignment term contributes nothing to the sum. Only the bench scenarios can show the exact modular arithmetic across wrap in both directions, the falling and quadrature spacing for particular divisors, the effect of mode on the offset sum, and the full walk up to a limit and back down to a divisor of zero.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

    typedef enum logic [1:0] {
        ADJ_HOLD  = 2'b00,
        ADJ_UP    = 2'b01,
        ADJ_DOWN  = 2'b10,
        ADJ_HOLD2 = 2'b11
    } adj_cmd_e;

    typedef enum logic {
        CS_BOOT = 1'b0,
        CS_RUN  = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/fdp_offset_sum.sv
module fdp_offset_sum #(
    parameter int NSRC      = 4,
    parameter int OFF_W     = 4,
    parameter int MASK_IDX  = 2,
    parameter int SUM_W     = OFF_W + $clog2(NSRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC*OFF_W-1:0]   off_flat_i,
    input  logic                    mask_en_i,
    output logic signed [SUM_W-1:0] sum_o
);

    logic signed [SUM_W-1:0] term [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_term
        if (g == MASK_IDX) begin : g_maskable
            assign term[g] = mask_en_i ? '0 :
                {{(SUM_W-OFF_W){off_flat_i[g*OFF_W+OFF_W-1]}}, off_flat_i[g*OFF_W +: OFF_W]};
        end else begin : g_plain
            assign term[g] =
                {{(SUM_W-OFF_W){off_flat_i[g*OFF_W+OFF_W-1]}}, off_flat_i[g*OFF_W +: OFF_W]};
        end
    end

    always_comb begin
        sum_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            sum_o = sum_o + term[i];
        end
    end

    localparam logic [NSRC*OFF_W-1:0] KEEP_MASK =
        ~({{(NSRC*OFF_W-OFF_W){1'b0}}, {OFF_W{1'b1}}} << (MASK_IDX*OFF_W));

    AST_ALIGN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en_i && ((off_flat_i & KEEP_MASK) == '0)) |-> (sum_o == '0)); // R6

endmodule

// File: rtl/fdp_div_ctrl.sv
module fdp_div_ctrl
    import fdp_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] load_val_i,
    input  logic             adj_en_i,
    input  logic [1:0]       cmd_i,
    input  logic [DIV_W-1:0] lim_min_i,
    input  logic [DIV_W-1:0] lim_max_i,
    output logic [DIV_W-1:0] div_o,
    output logic [DIV_W-1:0] div_nxt_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.div = load_val_i;
        end else if (adj_en_i) begin
            case (cmd_i)
                ADJ_UP:   if (st_q.div < lim_max_i) st_d.div = st_q.div + 1'b1;
                ADJ_DOWN: if (st_q.div > lim_min_i) st_d.div = st_q.div - 1'b1;
                default:  st_d.div = st_q.div;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_o     = st_q.div;
    assign div_nxt_o = st_d.div;

    AST_DIV_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_en_i && !load_i) |=> ((div_o == $past(div_o)) ||
                                   (div_o == $past(div_o) + 1'b1) ||
                                   (div_o == $past(div_o) - 1'b1))); // R7
    AST_DIV_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adj_en_i && !load_i) |=> $stable(div_o)); // R7
    AST_DIV_MAX_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_en_i && !load_i && cmd_i == ADJ_UP && div_o >= lim_max_i) |=> $stable(div_o)); // R8

endmodule

// File: rtl/fdp_phase_gen.sv
module fdp_phase_gen #(
    parameter int PH_W  = 6,
    parameter int SUM_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    step_i,
    input  logic [PH_W-1:0]         div_q_i,
    input  logic [PH_W-1:0]         div_d_i,
    input  logic signed [SUM_W-1:0] off_sum_i,
    output logic [PH_W-1:0]         rise_o,
    output logic [PH_W-1:0]         fall_o,
    output logic [PH_W-1:0]         quad_o
);

    localparam int PHASES = 2 ** PH_W;
    localparam int QTR    = PHASES / 4;
    localparam int ACC_W  = ((PH_W > SUM_W) ? PH_W : SUM_W) + 2;

    typedef struct packed {
        logic [PH_W-1:0] rise;
        logic [PH_W-1:0] fall;
        logic [PH_W-1:0] quad;
    } ph_st_t;

    ph_st_t st_d, st_q;

    logic signed [ACC_W-1:0] off_ext;
    logic signed [ACC_W-1:0] acc;
    logic [PH_W:0]           span;

    always_comb begin
        st_d    = st_q;
        off_ext = {{(ACC_W-SUM_W){off_sum_i[SUM_W-1]}}, off_sum_i};
        acc     = signed'({{(ACC_W-PH_W){1'b0}}, st_q.rise})
                + signed'({{(ACC_W-PH_W){1'b0}}, div_q_i})
                + off_ext;
        span    = {1'b1, {PH_W{1'b0}}} + {1'b0, div_d_i};
        if (clear_i) begin
            st_d.rise = '0;
        end else if (step_i) begin
            st_d.rise = acc[PH_W-1:0];
        end
        if (clear_i || step_i) begin
            st_d.fall = st_d.rise + span[PH_W:1];
            st_d.quad = st_d.rise + PH_W'(QTR);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;
    assign quad_o = st_q.quad;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_i) |=> $stable(rise_o)); // R3
    AST_ZERO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && div_q_i == '0 && off_sum_i == '0) |=> $stable(rise_o)); // R3

endmodule

// File: rtl/fdiv_phase_ctrl.sv
module fdiv_phase_ctrl
    import fdp_pkg::*;
#(
    parameter int PH_W  = 6,
    parameter int OFF_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dll_lock_i,
    input  logic                    start_i,
    input  logic                    mode_var_i,
    input  logic [PH_W-1:0]         cfg_div_i,
    input  logic [PH_W-1:0]         lim_min_i,
    input  logic [PH_W-1:0]         lim_max_i,
    input  logic [1:0]              adj_cmd_i,
    input  logic signed [OFF_W-1:0] off_volt_i,
    input  logic signed [OFF_W-1:0] off_shrink_i,
    input  logic signed [OFF_W-1:0] off_align_i,
    input  logic signed [OFF_W-1:0] off_test_i,
    output logic                    bypass_o,
    output logic                    edge_vld_o,
    output logic [PH_W-1:0]         rise_ph_o,
    output logic [PH_W-1:0]         fall_ph_o,
    output logic [PH_W-1:0]         quad_ph_o,
    output logic [PH_W-1:0]         div_o
);

    localparam int NSRC      = 4;
    localparam int ALIGN_IDX = 2;
    localparam int SUM_W     = OFF_W + $clog2(NSRC);

    typedef struct packed {
        ctl_state_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                    start_go;
    logic                    running;
    logic signed [SUM_W-1:0] off_sum;
    logic [PH_W-1:0]         div_nxt;

    assign running  = (ctl_q.st == CS_RUN);
    assign start_go = (ctl_q.st == CS_BOOT) && start_i && dll_lock_i;

    always_comb begin
        ctl_d = ctl_q;
        if (start_go) ctl_d.st = CS_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: CS_BOOT};
        else        ctl_q <= ctl_d;
    end

    fdp_offset_sum #(
        .NSRC     (NSRC),
        .OFF_W    (OFF_W),
        .MASK_IDX (ALIGN_IDX),
        .SUM_W    (SUM_W)
    ) u_offs (
        .clk        (clk),
        .rst_n      (rst_n),
        .off_flat_i ({off_test_i, off_align_i, off_shrink_i, off_volt_i}),
        .mask_en_i  (mode_var_i),
        .sum_o      (off_sum)
    );

    fdp_div_ctrl #(
        .DIV_W (PH_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_go),
        .load_val_i (cfg_div_i),
        .adj_en_i   (running && mode_var_i),
        .cmd_i      (adj_cmd_i),
        .lim_min_i  (lim_min_i),
        .lim_max_i  (lim_max_i),
        .div_o      (div_o),
        .div_nxt_o  (div_nxt)
    );

    fdp_phase_gen #(
        .PH_W  (PH_W),
        .SUM_W (SUM_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_go),
        .step_i    (running),
        .div_q_i   (div_o),
        .div_d_i   (div_nxt),
        .off_sum_i (off_sum),
        .rise_o    (rise_ph_o),
        .fall_o    (fall_ph_o),
        .quad_o    (quad_ph_o)
    );

    assign bypass_o   = (ctl_q.st == CS_BOOT);
    assign edge_vld_o = running;

    AST_BYPASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bypass_o && edge_vld_o)); // R1
    AST_FIRST_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_vld_o) |-> (rise_ph_o == '0)); // R2
    AST_WAIT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_o && !dll_lock_i) |=> bypass_o); // R2

endmodule

// File: tb/tb_fdiv_phase_ctrl.sv
`timescale 1ns/1ps
module tb_fdiv_phase_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dll_lock_i = 1'b0, start_i = 1'b0, mode_var_i = 1'b0;
    logic [5:0] cfg_div_i = '0, lim_min_i = '0, lim_max_i = 6'd63;
    logic [1:0] adj_cmd_i = 2'b00;
    logic signed [3:0] off_volt_i = '0, off_shrink_i = '0, off_align_i = '0, off_test_i = '0;
    logic       bypass_o, edge_vld_o;
    logic [5:0] rise_ph_o, fall_ph_o, quad_ph_o, div_o;

    always #2.5 clk = ~clk;

    fdiv_phase_ctrl dut (
        .clk(clk), .rst_n(rst_n), .dll_lock_i(dll_lock_i), .start_i(start_i),
        .mode_var_i(mode_var_i), .cfg_div_i(cfg_div_i), .lim_min_i(lim_min_i),
        .lim_max_i(lim_max_i), .adj_cmd_i(adj_cmd_i), .off_volt_i(off_volt_i),
        .off_shrink_i(off_shrink_i), .off_align_i(off_align_i), .off_test_i(off_test_i),
        .bypass_o(bypass_o), .edge_vld_o(edge_vld_o), .rise_ph_o(rise_ph_o),
        .fall_ph_o(fall_ph_o), .quad_ph_o(quad_ph_o), .div_o(div_o)
    );

    typedef struct {
        int    byp, vld, rise, fall, quad, dv;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    int m_run = 0, m_rise = 0, m_div = 0;

    task automatic chk(string tag, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver: advance the reference model with the inputs now applied and queue the result
    task automatic tick(string tag);
        exp_t e;
        int off;
        if (m_run == 0) begin
            if (start_i && dll_lock_i) begin
                m_run = 1; m_rise = 0; m_div = int'(cfg_div_i);
            end
        end else begin
            off = int'(off_volt_i) + int'(off_shrink_i) + int'(off_test_i)
                + (mode_var_i ? 0 : int'(off_align_i));
            m_rise = (((m_rise + m_div + off) % 64) + 64) % 64;
            if (mode_var_i) begin
                if (adj_cmd_i == 2'b01 && m_div < int'(lim_max_i)) m_div++;
                else if (adj_cmd_i == 2'b10 && m_div > int'(lim_min_i)) m_div--;
            end
        end
        e.byp  = m_run ? 0 : 1;
        e.vld  = m_run;
        e.rise = m_run ? m_rise : 0;
        e.fall = m_run ? (m_rise + (64 + m_div) / 2) % 64 : 0;
        e.quad = m_run ? (m_rise + 16) % 64 : 0;
        e.dv   = m_div;
        e.tag  = tag;
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare after each edge's updates have settled
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, "bypass", int'(bypass_o), e.byp);
            chk(e.tag, "valid", int'(edge_vld_o), e.vld);
            chk(e.tag, "rise", int'(rise_ph_o), e.rise);
            chk((e.tag == "R3") ? "R4" : e.tag, "fall", int'(fall_ph_o), e.fall);
            chk((e.tag == "R3") ? "R5" : e.tag, "quad", int'(quad_ph_o), e.quad);
            chk(e.tag, "div", int'(div_o), e.dv);
        end
    end

    task automatic set_off(int v, int s, int a, int t);
        off_volt_i = 4'(v); off_shrink_i = 4'(s); off_align_i = 4'(a); off_test_i = 4'(t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: boot state straight out of reset
        chk("R1", "bypass", int'(bypass_o), 1);
        chk("R1", "valid", int'(edge_vld_o), 0);
        chk("R1", "rise", int'(rise_ph_o), 0);
        chk("R1", "fall", int'(fall_ph_o), 0);
        chk("R1", "quad", int'(quad_ph_o), 0);
        chk("R1", "div", int'(div_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: start without lock is ignored
        start_i = 1; cfg_div_i = 6'd10;
        tick("R2"); tick("R2");
        // R2: lock plus start leaves bypass at tap 0
        dll_lock_i = 1;
        tick("R2");
        start_i = 0;
        // R3/R4/R5: plain stepping, fixed mode, no offsets
        for (int i = 0; i < 10; i++) tick("R3");
        // R2: a second start while running changes nothing
        start_i = 1; cfg_div_i = 6'd40;
        tick("R2");
        start_i = 0;
        // R6: all four offsets count in fixed mode
        set_off(3, -2, 5, -1);
        for (int i = 0; i < 4; i++) tick("R6");
        // R6: alignment dropped in variable mode
        mode_var_i = 1;
        for (int i = 0; i < 4; i++) tick("R6");
        // R6: negative offsets wrap below zero
        set_off(-8, -8, -8, -8);
        for (int i = 0; i < 4; i++) tick("R6");
        mode_var_i = 0;
        for (int i = 0; i < 3; i++) tick("R6");
        set_off(0, 0, 0, 0);
        // R7: requests ignored in fixed mode
        adj_cmd_i = 2'b01;
        for (int i = 0; i < 3; i++) tick("R7");
        // R8: upward saturation at the maximum
        mode_var_i = 1; lim_min_i = 6'd8; lim_max_i = 6'd12;
        for (int i = 0; i < 5; i++) tick("R8");
        // R7: hold encodings
        adj_cmd_i = 2'b11; tick("R7"); tick("R7");
        adj_cmd_i = 2'b00; tick("R7");
        // R8: downward saturation at the minimum
        adj_cmd_i = 2'b10;
        for (int i = 0; i < 7; i++) tick("R8");
        // R3: walk down to divisor 0, then pass-through with no motion
        lim_min_i = 6'd0;
        for (int i = 0; i < 12; i++) tick("R7");
        adj_cmd_i = 2'b00;
        for (int i = 0; i < 4; i++) tick("R3");
        // R8: climb to the top of the range
        lim_max_i = 6'd63; adj_cmd_i = 2'b01;
        for (int i = 0; i < 70; i++) tick("R8");
        adj_cmd_i = 2'b00; set_off(7, 7, 7, 7);
        for (int i = 0; i < 5; i++) tick("R3");
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule